// File: doc/BRIEF.md
# Serial Port FIFO and Interrupt Controller

This block sits between a synchronous serial shifter and a host bus. It keeps one transmit queue, filled by the host and drained by the shifter, and one receive queue, filled by the shifter and drained by the host. Both queues are show-ahead: the word at the head is always on the read data port, and a pop moves past it.

From the queue occupancies and three enable bits it raises three interrupt requests: a receive level request while the receive queue is at least half full, a transmit level request while the transmit queue is at most half full, and a receive overrun request. Overrun is sticky. It is set when the shifter delivers a word into a full receive queue and its enable is on. It is cleared only by writing the enable register with the overrun enable at 0, or by reset. A combined request is the OR of the three.

Top module: `sspi_fifo_irq`

## Requirements
- R1: After reset both queues are empty (`host_rx_empty`=1, `shf_tx_empty`=1, `host_tx_full`=0), all three enables are 0 and all four interrupt outputs are 0.
- R2: Each queue holds up to DEPTH (default 8) words of DATA_W (default 16) bits and returns them in push order; `host_tx_full` is 1 exactly when the transmit queue holds DEPTH words.
- R3: A push into a full queue is dropped and a pop from an empty queue does nothing; contents, order and later operation are unaffected, including when a pop lands in the same cycle as a dropped push.
- R4: `irq_rx_lvl` is 1 while the receive queue holds DEPTH/2 (4) or more words and the receive enable is 1, and it falls in the cycle after the count drops to 3.
- R5: `irq_tx_lvl` is 1 while the transmit queue holds DEPTH/2 (4) or fewer words and the transmit enable is 1.
- R6: A shifter push while the receive queue is full drops the new word and, if the overrun enable is 1, sets `irq_rx_ovr` from the next cycle.
- R7: Once set, `irq_rx_ovr` stays 1 until an enable write with bit 2 at 0. It is 0 from the cycle after that write, and setting the enable again does not bring it back.
- R8: An overrun while the overrun enable is 0 is not recorded, and enabling afterwards raises no overrun request.
- R9: `irq_any` is the OR of `irq_rx_lvl`, `irq_tx_lvl` and `irq_rx_ovr`.
- R10: With `ien_we`=1 the value of `ien_wdata` is loaded at the clock edge. Bit 0 enables the receive level request, bit 1 the transmit level request and bit 2 the overrun request. The interrupt outputs reflect the new value from the next cycle.
- R11: A push and a pop in the same cycle on a queue that is neither empty nor full leave its occupancy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_tx_push | input | 1 | Host writes a word into the transmit queue |
| host_tx_data | input | DATA_W | Word written by the host |
| host_tx_full | output | 1 | Transmit queue holds DEPTH words |
| host_rx_pop | input | 1 | Host removes the head of the receive queue |
| host_rx_data | output | DATA_W | Head of the receive queue |
| host_rx_empty | output | 1 | Receive queue is empty |
| shf_tx_pop | input | 1 | Shifter removes the head of the transmit queue |
| shf_tx_data | output | DATA_W | Head of the transmit queue |
| shf_tx_empty | output | 1 | Transmit queue is empty |
| shf_rx_push | input | 1 | Shifter delivers a received word |
| shf_rx_data | input | DATA_W | Received word |
| ien_we | input | 1 | Load the enable register |
| ien_wdata | input | 3 | Enables: bit0 rx level, bit1 tx level, bit2 overrun |
| irq_rx_lvl | output | 1 | Receive level request |
| irq_tx_lvl | output | 1 | Transmit level request |
| irq_rx_ovr | output | 1 | Sticky receive overrun request |
| irq_any | output | 1 | OR of the three requests |

## Verification
The bench pushes each queue past full to show that the dropped word never appears and the order is intact. A design that advanced the write pointer on a full push would return a stale or extra word. It walks the occupancy across the half threshold in both directions, so an off-by-one compare shows up as a request one word early or late. It checks that the overrun request survives draining and an enable rewrite with bit 2 still set, and that it clears only on a write with bit 2 at 0. It also checks that an overrun taken while disabled stays invisible after enabling, which catches a flag that is recorded unmasked. A simultaneous push and pop at the threshold would show a miscounted occupancy as a spurious change in the transmit request.

// File: rtl/sspi_fifo_pkg.sv
package sspi_fifo_pkg;

   // enable register layout: bit 0 rx level, bit 1 tx level, bit 2 overrun
   typedef struct packed {
      logic ovr;
      logic tx;
      logic rx;
   } ien_t;

   localparam int IEN_W = $bits(ien_t);

endpackage

// File: rtl/sspi_fifo_buf.sv
module sspi_fifo_buf #(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 8,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [DATA_W-1:0] wdata,
   input  logic              pop,
   output logic [DATA_W-1:0] rdata,
   output logic              full,
   output logic              empty,
   output logic [CNT_W-1:0]  count
);

   if (DEPTH < 2) begin : g_bad_depth
      $error("sspi_fifo_buf: DEPTH must be at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("sspi_fifo_buf: DATA_W must be positive");
   end

   logic [DATA_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic              do_push, do_pop;

   assign full    = (count == CNT_W'(DEPTH));
   assign empty   = (count == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign rdata   = mem[rd_ptr];

   // pointer wrap: free-running for powers of two, explicit compare otherwise
   if ((DEPTH & (DEPTH - 1)) == 0) begin : g_wrap_pow2
      assign wr_nxt = wr_ptr + PTR_W'(1);
      assign rd_nxt = rd_ptr + PTR_W'(1);
   end else begin : g_wrap_cmp
      assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + PTR_W'(1);
      assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + PTR_W'(1);
   end

   always_ff @(posedge clk) begin
      if (do_push) begin
         mem[wr_ptr] <= wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_nxt;
         if (do_pop)  rd_ptr <= rd_nxt;
         case ({do_push, do_pop})
            2'b10:   count <= count + CNT_W'(1);
            2'b01:   count <= count - CNT_W'(1);
            default: count <= count;
         endcase
      end
   end

   // R2
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(DEPTH));

   // R3
   full_push_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop) |=> (count == CNT_W'(DEPTH)));

   // R3
   empty_pop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && pop && !push) |=> empty);

   // R11
   both_ops_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && pop && !full && !empty) |=> $stable(count));

endmodule

// File: rtl/sspi_irq_ctl.sv
module sspi_irq_ctl
   import sspi_fifo_pkg::*;
#(
   parameter int DEPTH = 8,
   localparam int CNT_W = $clog2(DEPTH + 1),
   localparam int HALF  = DEPTH / 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] rx_count,
   input  logic [CNT_W-1:0] tx_count,
   input  logic             ovr_evt,
   input  logic             ien_we,
   input  ien_t             ien_wdata,
   output logic             irq_rx_lvl,
   output logic             irq_tx_lvl,
   output logic             irq_rx_ovr,
   output logic             irq_any
);

   if ((DEPTH % 2) != 0) begin : g_bad_half
      $error("sspi_irq_ctl: DEPTH must be even for a half threshold");
   end

   ien_t ien_q;
   logic ovr_flag;
   logic ovr_clr;

   assign ovr_clr = ien_we && !ien_wdata.ovr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ien_q    <= '0;
         ovr_flag <= 1'b0;
      end else begin
         if (ien_we) ien_q <= ien_wdata;
         if (ovr_clr) begin
            ovr_flag <= 1'b0;
         end else if (ovr_evt && ien_q.ovr) begin
            ovr_flag <= 1'b1;
         end
      end
   end

   assign irq_rx_lvl = ien_q.rx && (rx_count >= CNT_W'(HALF));
   assign irq_tx_lvl = ien_q.tx && (tx_count <= CNT_W'(HALF));
   assign irq_rx_ovr = ovr_flag && ien_q.ovr;
   assign irq_any    = irq_rx_lvl || irq_tx_lvl || irq_rx_ovr;

   // R7
   ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_rx_ovr && !ovr_clr) |=> irq_rx_ovr);

   // R7
   ovr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_clr |=> !irq_rx_ovr);

   // R6
   ovr_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_rx_ovr) |-> $past(ovr_evt));

   // R8
   ovr_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ien_q.ovr && !irq_rx_ovr && !(ien_we && ien_wdata.ovr)) |=> !irq_rx_ovr);

endmodule

// File: rtl/sspi_fifo_irq.sv
module sspi_fifo_irq
   import sspi_fifo_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_tx_push,
   input  logic [DATA_W-1:0] host_tx_data,
   output logic              host_tx_full,
   input  logic              host_rx_pop,
   output logic [DATA_W-1:0] host_rx_data,
   output logic              host_rx_empty,
   input  logic              shf_tx_pop,
   output logic [DATA_W-1:0] shf_tx_data,
   output logic              shf_tx_empty,
   input  logic              shf_rx_push,
   input  logic [DATA_W-1:0] shf_rx_data,
   input  logic              ien_we,
   input  logic [2:0]        ien_wdata,
   output logic              irq_rx_lvl,
   output logic              irq_tx_lvl,
   output logic              irq_rx_ovr,
   output logic              irq_any
);

   localparam int CNT_W = $clog2(DEPTH + 1);

   if (IEN_W != 3) begin : g_bad_ien
      $error("sspi_fifo_irq: enable register must be 3 bits");
   end

   logic [CNT_W-1:0] rx_count, tx_count;
   logic             rx_full;
   logic             ovr_evt;

   sspi_fifo_buf #(.DATA_W(DATA_W), .DEPTH(DEPTH)) tx_q_i (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (host_tx_push),
      .wdata (host_tx_data),
      .pop   (shf_tx_pop),
      .rdata (shf_tx_data),
      .full  (host_tx_full),
      .empty (shf_tx_empty),
      .count (tx_count)
   );

   sspi_fifo_buf #(.DATA_W(DATA_W), .DEPTH(DEPTH)) rx_q_i (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (shf_rx_push),
      .wdata (shf_rx_data),
      .pop   (host_rx_pop),
      .rdata (host_rx_data),
      .full  (rx_full),
      .empty (host_rx_empty),
      .count (rx_count)
   );

   assign ovr_evt = shf_rx_push && rx_full;

   sspi_irq_ctl #(.DEPTH(DEPTH)) irq_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .rx_count   (rx_count),
      .tx_count   (tx_count),
      .ovr_evt    (ovr_evt),
      .ien_we     (ien_we),
      .ien_wdata  (ien_t'(ien_wdata)),
      .irq_rx_lvl (irq_rx_lvl),
      .irq_tx_lvl (irq_tx_lvl),
      .irq_rx_ovr (irq_rx_ovr),
      .irq_any    (irq_any)
   );

   // R9
   any_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_rx_lvl || irq_tx_lvl || irq_rx_ovr) |-> irq_any);

   // R6
   ovr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_evt && !host_rx_pop) |=> !host_rx_empty);

endmodule

// File: tb/sspi_fifo_irq_tb_top.sv
module sspi_fifo_irq_tb_top;

   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          host_tx_push = 1'b0;
   logic [DW-1:0] host_tx_data = '0;
   logic          host_tx_full;
   logic          host_rx_pop = 1'b0;
   logic [DW-1:0] host_rx_data;
   logic          host_rx_empty;
   logic          shf_tx_pop = 1'b0;
   logic [DW-1:0] shf_tx_data;
   logic          shf_tx_empty;
   logic          shf_rx_push = 1'b0;
   logic [DW-1:0] shf_rx_data = '0;
   logic          ien_we = 1'b0;
   logic [2:0]    ien_wdata = '0;
   logic          irq_rx_lvl, irq_tx_lvl, irq_rx_ovr, irq_any;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   sspi_fifo_irq #(.DATA_W(DW), .DEPTH(8)) dut_i (.*);

   // ops: 0 host tx push, 1 shifter tx pop, 2 shifter rx push, 3 host rx pop, 4 enable write
   typedef struct packed {
      logic [2:0]  op;
      logic [15:0] din;
      logic [15:0] dexp;
      logic [3:0]  irq;   // {rx_lvl, tx_lvl, rx_ovr, any}
   } vec_t;

   localparam vec_t VEC [13] = '{
      '{3'd4, 16'h0003, 16'h0000, 4'b0101},
      '{3'd2, 16'h1111, 16'h0000, 4'b0101},
      '{3'd2, 16'h2222, 16'h0000, 4'b0101},
      '{3'd2, 16'h3333, 16'h0000, 4'b0101},
      '{3'd2, 16'h4444, 16'h0000, 4'b1101},
      '{3'd3, 16'h0000, 16'h1111, 4'b0101},
      '{3'd0, 16'h5001, 16'h0000, 4'b0101},
      '{3'd0, 16'h5002, 16'h0000, 4'b0101},
      '{3'd0, 16'h5003, 16'h0000, 4'b0101},
      '{3'd0, 16'h5004, 16'h0000, 4'b0101},
      '{3'd0, 16'h5005, 16'h0000, 4'b0000},
      '{3'd1, 16'h0000, 16'h5001, 4'b0101},
      '{3'd4, 16'h0004, 16'h0000, 4'b0000}
   };

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic cyc();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic tx_push(logic [15:0] d);
      host_tx_push = 1'b1; host_tx_data = d; cyc(); host_tx_push = 1'b0;
   endtask
   task automatic tx_pop();
      shf_tx_pop = 1'b1; cyc(); shf_tx_pop = 1'b0;
   endtask
   task automatic rx_push(logic [15:0] d);
      shf_rx_push = 1'b1; shf_rx_data = d; cyc(); shf_rx_push = 1'b0;
   endtask
   task automatic rx_pop();
      host_rx_pop = 1'b1; cyc(); host_rx_pop = 1'b0;
   endtask
   task automatic en_wr(logic [2:0] v);
      ien_we = 1'b1; ien_wdata = v; cyc(); ien_we = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   function automatic logic [3:0] irqs();
      return {irq_rx_lvl, irq_tx_lvl, irq_rx_ovr, irq_any};
   endfunction

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      do_reset();
      // R1 reset state
      chk("R1 rx empty", host_rx_empty, 1);
      chk("R1 tx empty", shf_tx_empty, 1);
      chk("R1 tx not full", host_tx_full, 0);
      chk("R1 irqs low with enables 0", irqs(), 4'b0000);

      // table walk: R4 R5 R9 R10 and ordering
      foreach (VEC[i]) begin
         case (VEC[i].op)
            3'd0: tx_push(VEC[i].din);
            3'd1: begin chk("R2 tx head", shf_tx_data, VEC[i].dexp); tx_pop(); end
            3'd2: rx_push(VEC[i].din);
            3'd3: begin chk("R2 rx head", host_rx_data, VEC[i].dexp); rx_pop(); end
            default: en_wr(VEC[i].din[2:0]);
         endcase
         chk($sformatf("R4/R5/R9/R10 vector %0d irqs", i), irqs(), VEC[i].irq);
      end

      // R2 R3: fill transmit queue, drop extra push, drain in order
      do_reset();
      for (int i = 0; i < 8; i++) tx_push(16'hA000 + 16'(i));
      chk("R2 tx full at 8", host_tx_full, 1);
      tx_push(16'hDEAD);
      chk("R3 still full after dropped push", host_tx_full, 1);
      for (int i = 0; i < 8; i++) begin
         chk("R2 tx order", shf_tx_data, 16'hA000 + 16'(i));
         tx_pop();
      end
      chk("R3 empty after 8 pops", shf_tx_empty, 1);
      tx_pop();
      chk("R3 pop on empty keeps empty", shf_tx_empty, 1);
      tx_push(16'h7777);
      chk("R3 queue works after empty pop", shf_tx_data, 16'h7777);
      tx_pop();

      // R3: dropped push in same cycle as pop
      for (int i = 0; i < 8; i++) tx_push(16'hB000 + 16'(i));
      host_tx_push = 1'b1; host_tx_data = 16'hDEAD; shf_tx_pop = 1'b1;
      cyc();
      host_tx_push = 1'b0; shf_tx_pop = 1'b0;
      chk("R3 full push with pop drops word", host_tx_full, 0);
      for (int i = 1; i < 8; i++) begin
         chk("R3 order after full push+pop", shf_tx_data, 16'hB000 + 16'(i));
         tx_pop();
      end
      chk("R3 no extra word", shf_tx_empty, 1);

      // R11 R5: simultaneous push and pop at threshold
      en_wr(3'b010);
      for (int i = 0; i < 4; i++) tx_push(16'hC000 + 16'(i));
      chk("R5 tx irq at 4", irq_tx_lvl, 1);
      host_tx_push = 1'b1; host_tx_data = 16'hC004; shf_tx_pop = 1'b1;
      cyc();
      host_tx_push = 1'b0; shf_tx_pop = 1'b0;
      chk("R11 count held at 4", irq_tx_lvl, 1);
      chk("R11 head advanced", shf_tx_data, 16'hC001);
      tx_push(16'hC005);
      chk("R5 tx irq off at 5", irq_tx_lvl, 0);

      // R6 R7 R9: overrun with enable set
      do_reset();
      en_wr(3'b100);
      for (int i = 0; i < 8; i++) rx_push(16'hD000 + 16'(i));
      chk("R6 no overrun before extra push", irq_rx_ovr, 0);
      rx_push(16'hBEEF);
      chk("R6 overrun raised", irq_rx_ovr, 1);
      chk("R9 any follows overrun", irq_any, 1);
      for (int i = 0; i < 8; i++) begin
         chk("R6 rx contents unchanged", host_rx_data, 16'hD000 + 16'(i));
         rx_pop();
      end
      chk("R6 dropped word absent", host_rx_empty, 1);
      chk("R7 overrun sticky after drain", irq_rx_ovr, 1);
      en_wr(3'b100);
      chk("R7 rewrite with bit2 set keeps it", irq_rx_ovr, 1);
      en_wr(3'b000);
      chk("R7 cleared by writing 0", irq_rx_ovr, 0);
      en_wr(3'b100);
      chk("R7 re-enable does not revive", irq_rx_ovr, 0);

      // R8 R4: overrun while disabled, receive threshold boundary
      en_wr(3'b000);
      for (int i = 0; i < 9; i++) rx_push(16'hE000 + 16'(i));
      en_wr(3'b101);
      chk("R8 masked overrun not recorded", irq_rx_ovr, 0);
      chk("R4 rx irq at 8", irq_rx_lvl, 1);
      for (int i = 0; i < 4; i++) rx_pop();
      chk("R4 rx irq at 4", irq_rx_lvl, 1);
      chk("R4 head after 4 pops", host_rx_data, 16'hE004);
      rx_pop();
      chk("R4 rx irq off at 3", irq_rx_lvl, 0);

      // R10: bit positions
      en_wr(3'b001);
      chk("R10 bit0 alone leaves tx irq off", irq_tx_lvl, 0);
      en_wr(3'b010);
      chk("R10 bit1 enables tx irq", irq_tx_lvl, 1);
      chk("R10 bit0 cleared", irq_rx_lvl, 0);
      chk("R9 any with tx only", irq_any, 1);

      finish_run();
   end

endmodule